// File: doc/BRIEF.md
# Programmable Two-Level Logic Array

This block is a sum-of-products array that is configured at run time. A bank of product terms forms the first plane. Each term is an AND of literals taken from the data inputs. The second plane ORs the selected terms onto each output. A configuration word per term sets which inputs the term uses and with which polarity. It also sets the outputs that the term drives. Software or a sequencer loads the array one term per clock. After that the outputs follow the data inputs with no clock in the path.

A mode input picks how much freedom the OR plane has. In shared mode, any term may drive any output, and one term may drive several outputs at once. In grouped mode, each output may only use its own block of consecutive terms, and any connection bit outside that block is ignored. The number of terms is fixed by a parameter. A set of functions that needs more distinct terms than the array holds cannot be loaded.

Top module: `pla_array`

## Requirements
- R1: Each input of a term is coded in 2 bits at positions [2i+1:2i] of the AND word: 2'b01 needs input i high, 2'b10 needs it low, 2'b00 leaves it out, and 2'b11 forces the term to 0.
- R2: A term whose literals are all 2'b00 evaluates to 1.
- R3: Each output is the OR of the terms connected to it. An output with no connected terms reads 0.
- R4: With `pal_mode` low, bit o of a term's OR word connects that term to output o for any term index. One term may drive several outputs.
- R5: With `pal_mode` high, output o sees only terms o*G to o*G+G-1, where G = N_TERM/N_OUT (4 by default). OR bits outside that group have no effect.
- R6: When `cfg_we` is high at a rising edge, the AND and OR words are stored for term `cfg_term`. Outputs change only after that edge. Without a write, the stored configuration does not change.
- R7: Reset clears both planes, so every output reads 0 until terms are connected.
- R8: With no clock edge needed, the outputs follow `din` and `pal_mode`.
- R9: A four-input code converter with one group per output evaluates correctly for all 16 inputs in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one term |
| cfg_term | input | TW | Index of the term being written |
| cfg_and | input | 2*N_IN | AND-plane word, 2 bits per input |
| cfg_or | input | N_OUT | OR-plane word, 1 bit per output |
| pal_mode | input | 1 | 1 = grouped OR plane, 0 = shared OR plane |
| din | input | N_IN | Data inputs |
| dout | output | N_OUT | Sum-of-products outputs |

## Verification
The assertions assume that `cfg_term` always names an existing term and that N_TERM is a whole multiple of N_OUT. The bench only writes indices from 0 to 15 with the default sizes. The assertions also assume that the stored configuration only moves on a write edge. For that reason the bench drives every configuration and data change on the falling edge, and it samples one time unit later. The check of the moment a write takes effect is made in the half cycle before the rising edge and again after it.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_INV  = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  // One literal's contribution to its product term
  function automatic logic lit_pass(input logic [1:0] code, input logic bit_in);
    case (lit_code_e'(code))
      LIT_OFF:  lit_pass = 1'b1;
      LIT_TRUE: lit_pass = bit_in;
      LIT_INV:  lit_pass = ~bit_in;
      default:  lit_pass = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  localparam int TW    = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [TW-1:0]                      idx,
  input  logic [2*N_IN-1:0]                  and_w,
  input  logic [N_OUT-1:0]                   or_w,
  output logic [N_TERM-1:0][2*N_IN-1:0]      and_q,
  output logic [N_TERM-1:0][N_OUT-1:0]       or_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_q <= '0;
      or_q  <= '0;
    end else if (we) begin
      and_q[idx] <= and_w;
      or_q[idx]  <= or_w;
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 16
) (
  input  logic [N_TERM-1:0][2*N_IN-1:0] and_cfg,
  input  logic [N_IN-1:0]               din,
  output logic [N_TERM-1:0]             term_hit
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] lit_ok;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit_ok[i] = lit_pass(and_cfg[t][2*i+1:2*i], din[i]);
    end
    assign term_hit[t] = &lit_ok;
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  localparam int GRP   = N_TERM / N_OUT
) (
  input  logic [N_TERM-1:0][N_OUT-1:0] or_cfg,
  input  logic [N_TERM-1:0]            term_hit,
  input  logic                         pal_mode,
  output logic [N_TERM-1:0][N_OUT-1:0] or_eff,
  output logic [N_OUT-1:0]             dout
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    for (genvar o = 0; o < N_OUT; o++) begin : g_col
      localparam bit IN_GRP = ((t / GRP) == o);
      assign or_eff[t][o] = or_cfg[t][o] & (IN_GRP | ~pal_mode);
    end
  end

  always_comb begin
    dout = '0;
    for (int t = 0; t < N_TERM; t++) begin
      dout = dout | (or_eff[t] & {N_OUT{term_hit[t]}});
    end
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  localparam int TW    = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TW-1:0]     cfg_term,
  input  logic [2*N_IN-1:0] cfg_and,
  input  logic [N_OUT-1:0]  cfg_or,
  input  logic              pal_mode,
  input  logic [N_IN-1:0]   din,
  output logic [N_OUT-1:0]  dout
);
  logic [N_TERM-1:0][2*N_IN-1:0] and_cfg;
  logic [N_TERM-1:0][N_OUT-1:0]  or_cfg;
  logic [N_TERM-1:0][N_OUT-1:0]  or_eff;
  logic [N_TERM-1:0]             term_hit;

  pla_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_term),
    .and_w(cfg_and), .or_w(cfg_or), .and_q(and_cfg), .or_q(or_cfg)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .and_cfg(and_cfg), .din(din), .term_hit(term_hit)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .or_cfg(or_cfg), .term_hit(term_hit), .pal_mode(pal_mode),
    .or_eff(or_eff), .dout(dout)
  );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  localparam int TW    = (N_TERM > 1) ? $clog2(N_TERM) : 1,
  localparam int GRP   = N_TERM / N_OUT
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we,
  input logic [TW-1:0]                 cfg_term,
  input logic [2*N_IN-1:0]             cfg_and,
  input logic [N_OUT-1:0]              cfg_or,
  input logic                          pal_mode,
  input logic [N_OUT-1:0]              dout,
  input logic [N_TERM-1:0][2*N_IN-1:0] and_cfg,
  input logic [N_TERM-1:0][N_OUT-1:0]  or_cfg,
  input logic [N_TERM-1:0][N_OUT-1:0]  or_eff,
  input logic [N_TERM-1:0]             term_hit
);
  // R6
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (or_cfg[$past(cfg_term)] == $past(cfg_or)) &&
               (and_cfg[$past(cfg_term)] == $past(cfg_and)));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(or_cfg) && $stable(and_cfg));

  // R7
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (or_cfg == '0) && (dout == '0));

  // R3
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dout) |-> (|term_hit));

  for (genvar t = 0; t < N_TERM; t++) begin : g_t
    logic kill_any, all_off;
    always_comb begin
      kill_any = 1'b0;
      all_off  = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (and_cfg[t][2*i +: 2] == 2'b11) kill_any = 1'b1;
        if (and_cfg[t][2*i +: 2] != 2'b00) all_off  = 1'b0;
      end
    end

    // R1
    kill_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_any |-> !term_hit[t]);

    // R2
    free_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_off |-> term_hit[t]);

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
      if ((t / GRP) != o) begin : g_out
        // R5
        grp_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
          pal_mode |-> !or_eff[t][o]);
      end
    end
  end
endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_term(cfg_term),
  .cfg_and(cfg_and), .cfg_or(cfg_or), .pal_mode(pal_mode), .dout(dout),
  .and_cfg(and_cfg), .or_cfg(or_cfg), .or_eff(or_eff), .term_hit(term_hit)
);

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_term = '0;
  logic [7:0] cfg_and = '0;
  logic [3:0] cfg_or = '0;
  logic       pal_mode = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [1:0] X_ = 2'b00, T_ = 2'b01, N_ = 2'b10, K_ = 2'b11;

  always #10 clk = ~clk;

  pla_array dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_term(cfg_term),
    .cfg_and(cfg_and), .cfg_or(cfg_or), .pal_mode(pal_mode),
    .din(din), .dout(dout)
  );

  // din[3]=A din[2]=B din[1]=C din[0]=D; literal of input i sits at [2i+1:2i]
  function automatic logic [7:0] aw(logic [1:0] a, logic [1:0] b, logic [1:0] c, logic [1:0] d);
    return {a, b, c, d};
  endfunction

  function automatic logic [3:0] conv(logic [3:0] v);
    logic a, b, c, d;
    {a, b, c, d} = v;
    conv[0] = a | (b & d) | (b & c);
    conv[1] = b & ~c;
    conv[2] = b | c;
    conv[3] = (~a & ~b & ~c & d) | (b & c & d) | (a & ~d) | (~b & c & ~d);
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s din=%h mode=%0b actual=%h expected=%h", req, din, pal_mode, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [7:0] a, logic [3:0] o);
    @(negedge clk);
    cfg_we = 1'b1; cfg_term = 4'(idx); cfg_and = a; cfg_or = o;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setin(logic [3:0] v, logic m);
    din = v; pal_mode = m; #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset leaves outputs at 0 for every input
    for (int v = 0; v < 16; v++) begin setin(4'(v), v[0]); chk("R7", dout, 4'h0); end
    rst_n = 1'b1;
    @(negedge clk);
    setin(4'hF, 1'b0); chk("R7", dout, 4'h0);

    // R9: converter, one group of 4 terms per output
    wr(0,  aw(T_, X_, X_, X_), 4'b0001);
    wr(1,  aw(X_, T_, X_, T_), 4'b0001);
    wr(2,  aw(X_, T_, T_, X_), 4'b0001);
    wr(4,  aw(X_, T_, N_, X_), 4'b0010);
    wr(8,  aw(X_, T_, X_, X_), 4'b0100);
    wr(9,  aw(X_, X_, T_, X_), 4'b0100);
    wr(12, aw(N_, N_, N_, T_), 4'b1000);
    wr(13, aw(X_, T_, T_, T_), 4'b1000);
    wr(14, aw(T_, X_, X_, N_), 4'b1000);
    wr(15, aw(X_, N_, T_, N_), 4'b1000);
    // R9 R8 R1: exhaustive sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 16; v++) begin
        setin(4'(v), m[0]); chk("R9", dout, conv(4'(v)));
      end

    // R6: write term 5 (always true) onto W; no change before the edge
    setin(4'h0, 1'b0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_term = 4'd5; cfg_and = aw(X_, X_, X_, X_); cfg_or = 4'b0001;
    #1 chk("R6", dout, conv(4'h0));
    @(negedge clk);
    cfg_we = 1'b0; cfg_and = aw(K_, K_, K_, K_); cfg_or = 4'hF;
    #1;
    // R2 R4: free term in another group drives W in shared mode
    for (int v = 0; v < 16; v++) begin
      setin(4'(v), 1'b0); chk("R4", dout, conv(4'(v)) | 4'b0001);
    end
    // R5: same connection ignored in grouped mode
    for (int v = 0; v < 16; v++) begin
      setin(4'(v), 1'b1); chk("R5", dout, conv(4'(v)));
    end
    // R6: strobe low with other words present leaves config alone
    @(negedge clk); @(negedge clk);
    setin(4'h0, 1'b0); chk("R6", dout, 4'b0001 | conv(4'h0));
    wr(5, aw(X_, X_, X_, X_), 4'b0000);

    // R1: a 2'b11 code kills term 4, so X stays 0
    wr(4, aw(X_, T_, N_, K_), 4'b0010);
    for (int v = 0; v < 16; v++) begin
      setin(4'(v), 1'b0); chk("R1", dout, conv(4'(v)) & 4'b1101);
    end
    wr(4, aw(X_, T_, N_, X_), 4'b0010);
    setin(4'b0100, 1'b0); chk("R1", dout, conv(4'b0100));

    // R3: disconnect Y's terms, Y reads 0
    wr(8, aw(X_, T_, X_, X_), 4'b0000);
    wr(9, aw(X_, X_, T_, X_), 4'b0000);
    for (int v = 0; v < 16; v++) begin
      setin(4'(v), 1'b1); chk("R3", dout, conv(4'(v)) & 4'b1011);
    end

    // R4: one term shared by W and Z in shared mode
    wr(0, aw(T_, X_, X_, X_), 4'b1001);
    for (int v = 8; v < 16; v++) begin
      setin(4'(v), 1'b0); chk("R4", dout, (conv(4'(v)) & 4'b1011) | 4'b1001);
    end

    // R7: reset again clears the planes
    @(negedge clk); rst_n = 1'b0; #1;
    setin(4'hF, 1'b0); chk("R7", dout, 4'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule